// File: doc/BRIEF.md
# Quaternary Line Transmit Framer

This block builds the outgoing bit stream for one end of a basic-rate digital subscriber loop. It carries two 64 kbit/s bearer channels (B1, B2) and one 16 kbit/s signalling channel (D), plus 16 kbit/s of sync and overhead, for 160 kbit/s on the wire. The block adds a nine-symbol sync word and six maintenance bits to each frame and scrambles everything except the sync word. Each bit pair then becomes one of four line levels, so symbols leave at 80 kbaud.

A frame is 120 symbols. Twelve frames make a superframe, and the first frame of each superframe carries the sync word with its signs flipped. User data is pulled in 18-bit groups: the block strobes `grp_take` and latches 8 B1 bits, 8 B2 bits and 2 D bits in that edge. Until the receiver has superframe lock (`sync_ok` low), the payload slots carry all ones instead of user data. The `mode_nt` input picks the end of the loop, and with it the scrambler taps. The output is a signed 2-bit level code with a one-cycle strobe per symbol. Pulse shaping and the analog stage come after this block.

Top module: `qline_tx_framer`

## Requirements
- R1: `sym_stb` is high for exactly one clock cycle every `SYM_DIV` cycles (`SYM_DIV` >= 2). After reset, the first strobe follows after `SYM_DIV` cycles.
- R2: A frame has 120 symbols. Symbols 0..8 of frames 1..11 carry the unscrambled sync levels +3 +3 -3 -3 -3 +3 -3 +3 +3. The sync symbols do not advance the scrambler.
- R3: Frame 0 of each 12-frame superframe carries the sign-inverted sync word. `sf_start` is high together with the strobe of its first symbol, and at no other time. This happens every 1440 symbols.
- R4: `grp_take` pulses in the cycle before the symbol positions 9+9g (g = 0..11) are emitted. In that edge the block latches {`b1_in`, `b2_in`, `d_in`}. These 18 bits are sent MSB first, two per symbol, in symbols 9+9g .. 17+9g.
- R5: Symbols 117..119 carry `oh_in[5:0]` MSB first. `oh_in` is sampled in the cycle before symbol 117 is emitted.
- R6: When `mode_nt`=1, every payload and overhead bit is scrambled as out(n) = in(n) ^ out(n-5) ^ out(n-23). The first bit of each pair is processed first.
- R7: When `mode_nt`=0, the same rule applies with taps n-18 and n-23.
- R8: When `sync_ok` is low at a `grp_take` edge, that group sends 18 ones (before scrambling) instead of the input data.
- R9: A scrambled pair (first bit = sign, second bit = magnitude) maps as follows: 10 -> +3 -> code 01, 11 -> +1 -> code 00, 01 -> -1 -> code 11, 00 -> -3 -> code 10. Each code is the two's-complement value c, and the line level is 2c+1.
- R10: During reset, `sym_stb`, `sf_start` and `sym_code` are 0. Reset clears the scrambler history to zeros and restarts at frame 0, symbol 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_nt | input | 1 | 1 = network-terminator end, 0 = line-terminator end |
| sync_ok | input | 1 | Superframe lock acquired; enables user payload |
| b1_in | input | CH_W | B1 byte for the next group |
| b2_in | input | CH_W | B2 byte for the next group |
| d_in | input | D_W | D bits for the next group |
| oh_in | input | OH_BITS | Maintenance bits for the current frame |
| grp_take | output | 1 | Group data latched at this edge |
| sym_stb | output | 1 | One-cycle symbol strobe |
| sym_code | output | 2 | Signed level code, level = 2*code+1 |
| sf_start | output | 1 | First symbol of a superframe |

## Verification
The bench builds the block with `SYM_DIV`=3 and the default frame geometry, so one superframe takes 4320 cycles. Each run therefore crosses a superframe wrap and reaches the second inverted sync word. It runs one phase per mode, which exercises both scrambler tap sets against an independent history model. It also toggles `sync_ok` between groups, so that gated and open groups both reach the scrambler with their history carried over.

// File: rtl/qtx_pkg.sv
package qtx_pkg;
  typedef logic [1:0] qcode_t;

  localparam qcode_t Q_P3 = 2'b01;
  localparam qcode_t Q_P1 = 2'b00;
  localparam qcode_t Q_M1 = 2'b11;
  localparam qcode_t Q_M3 = 2'b10;

  localparam int SYNC_SYMS = 9;
  // sign of each sync symbol, symbol 0 in the top bit (1 = +3)
  localparam logic [8:0] SYNC_SIGNS = 9'b110001011;

  // sign bit first, magnitude bit second
  function automatic qcode_t map_pair(input logic sgn, input logic mag);
    return {~sgn, sgn ^ mag};
  endfunction

  function automatic qcode_t sync_code(input logic [3:0] idx, input logic inv);
    logic s;
    s = SYNC_SIGNS[4'd8 - idx] ^ inv;
    return s ? Q_P3 : Q_M3;
  endfunction
endpackage

// File: rtl/qtx_timebase.sv
module qtx_timebase #(
  parameter int SYM_DIV    = 4,
  parameter int FRAME_SYMS = 120,
  parameter int SF_FRAMES  = 12,
  localparam int DIV_W = $clog2(SYM_DIV),
  localparam int POS_W = $clog2(FRAME_SYMS),
  localparam int FR_W  = $clog2(SF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [POS_W-1:0] pos,
  output logic [FR_W-1:0]  frame
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYM_DIV - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_SYMS - 1);
  localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(SF_FRAMES - 1);

  logic [DIV_W-1:0] div_q;
  logic             pos_wrap;

  assign tick     = (div_q == DIV_LAST);
  assign pos_wrap = (pos == POS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      pos   <= '0;
      frame <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        pos <= pos_wrap ? '0 : pos + 1'b1;
        if (pos_wrap) frame <= (frame == FR_LAST) ? '0 : frame + 1'b1;
      end
    end
  end

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos_wrap) |=> (pos == '0));
  // R3
  sf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos_wrap && frame == FR_LAST) |=> (frame == '0));
endmodule

// File: rtl/qtx_payload.sv
module qtx_payload #(
  parameter int FRAME_SYMS = 120,
  parameter int CH_W       = 8,
  parameter int D_W        = 2,
  parameter int OH_BITS    = 6,
  localparam int POS_W     = $clog2(FRAME_SYMS),
  localparam int GRP_BITS  = 2 * CH_W + D_W,
  localparam int GRP_SYMS  = GRP_BITS / 2,
  localparam int GS_W      = $clog2(GRP_SYMS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [POS_W-1:0]   pos,
  input  logic               sync_ok,
  input  logic [CH_W-1:0]    b1_in,
  input  logic [CH_W-1:0]    b2_in,
  input  logic [D_W-1:0]     d_in,
  input  logic [OH_BITS-1:0] oh_in,
  output logic               grp_take,
  output logic [1:0]         pair
);
  localparam logic [POS_W-1:0] PAY_FIRST = POS_W'(qtx_pkg::SYNC_SYMS);
  localparam logic [POS_W-1:0] OH_FIRST  = POS_W'(FRAME_SYMS - OH_BITS / 2);
  localparam logic [GS_W-1:0]  GS_LAST   = GS_W'(GRP_SYMS - 1);

  logic [GS_W-1:0]     gsub;
  logic [GRP_BITS-1:0] grp_q;
  logic [GRP_BITS-1:0] gated;
  logic [OH_BITS-1:0]  oh_q;
  logic                in_pay;
  logic                in_oh;
  logic                oh_start;

  assign in_pay   = (pos >= PAY_FIRST) && (pos < OH_FIRST);
  assign in_oh    = (pos >= OH_FIRST);
  assign oh_start = tick && (pos == OH_FIRST);
  assign grp_take = tick && in_pay && (gsub == '0);
  assign gated    = sync_ok ? {b1_in, b2_in, d_in} : {GRP_BITS{1'b1}};

  always_comb begin
    if (grp_take)      pair = gated[GRP_BITS-1 -: 2];
    else if (oh_start) pair = oh_in[OH_BITS-1 -: 2];
    else if (in_oh)    pair = oh_q[OH_BITS-1 -: 2];
    else               pair = grp_q[GRP_BITS-1 -: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gsub  <= '0;
      grp_q <= '0;
      oh_q  <= '0;
    end else if (tick) begin
      if (in_pay) gsub <= (gsub == GS_LAST) ? '0 : gsub + 1'b1;
      else        gsub <= '0;
      if (grp_take)    grp_q <= {gated[GRP_BITS-3:0], 2'b00};
      else if (in_pay) grp_q <= {grp_q[GRP_BITS-3:0], 2'b00};
      if (oh_start)    oh_q <= {oh_in[OH_BITS-3:0], 2'b00};
      else if (in_oh)  oh_q <= {oh_q[OH_BITS-3:0], 2'b00};
    end
  end

  // R8
  gate_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_take && !sync_ok) |=> (grp_q == {{(GRP_BITS-2){1'b1}}, 2'b00}));
endmodule

// File: rtl/qtx_scrambler.sv
module qtx_scrambler #(
  parameter int LEN    = 23,
  parameter int TAP_NT = 5,
  parameter int TAP_LT = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       mode_nt,
  input  logic [1:0] pair,
  output logic [1:0] spair
);
  logic [LEN-1:0] hist;
  logic [LEN-1:0] mid;
  logic [LEN-1:0] nxt;

  // hist[0] is the newest output bit
  function automatic logic scr_bit(input logic [LEN-1:0] h, input logic din,
                                   input logic nt);
    return din ^ (nt ? h[TAP_NT-1] : h[TAP_LT-1]) ^ h[LEN-1];
  endfunction

  always_comb begin
    spair[1] = scr_bit(hist, pair[1], mode_nt);
    mid      = {hist[LEN-2:0], spair[1]};
    spair[0] = scr_bit(mid, pair[0], mode_nt);
    nxt      = {mid[LEN-2:0], spair[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   hist <= '0;
    else if (adv) hist <= nxt;
  end

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(hist));
endmodule

// File: rtl/qline_tx_framer.sv
module qline_tx_framer #(
  parameter int SYM_DIV    = 4,
  parameter int FRAME_SYMS = 120,
  parameter int SF_FRAMES  = 12,
  parameter int CH_W       = 8,
  parameter int D_W        = 2,
  parameter int OH_BITS    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_nt,
  input  logic               sync_ok,
  input  logic [CH_W-1:0]    b1_in,
  input  logic [CH_W-1:0]    b2_in,
  input  logic [D_W-1:0]     d_in,
  input  logic [OH_BITS-1:0] oh_in,
  output logic               grp_take,
  output logic               sym_stb,
  output logic [1:0]         sym_code,
  output logic               sf_start
);
  import qtx_pkg::*;

  localparam int POS_W   = $clog2(FRAME_SYMS);
  localparam int FR_W    = $clog2(SF_FRAMES);
  localparam int SF_SYMS = FRAME_SYMS * SF_FRAMES;
  localparam int CNT_W   = $clog2(SF_SYMS + 1);
  localparam logic [POS_W-1:0] SYNC_END = POS_W'(SYNC_SYMS);

  logic             tick;
  logic [POS_W-1:0] pos;
  logic [FR_W-1:0]  frame;
  logic [1:0]       pair;
  logic [1:0]       spair;
  logic             is_sync;
  logic             scr_adv;
  qcode_t           code_nxt;
  logic             out_is_sync;

  qtx_timebase #(.SYM_DIV(SYM_DIV), .FRAME_SYMS(FRAME_SYMS), .SF_FRAMES(SF_FRAMES))
    u_tb (.clk(clk), .rst_n(rst_n), .tick(tick), .pos(pos), .frame(frame));

  qtx_payload #(.FRAME_SYMS(FRAME_SYMS), .CH_W(CH_W), .D_W(D_W), .OH_BITS(OH_BITS))
    u_pay (.clk(clk), .rst_n(rst_n), .tick(tick), .pos(pos), .sync_ok(sync_ok),
           .b1_in(b1_in), .b2_in(b2_in), .d_in(d_in), .oh_in(oh_in),
           .grp_take(grp_take), .pair(pair));

  qtx_scrambler u_scr (.clk(clk), .rst_n(rst_n), .adv(scr_adv), .mode_nt(mode_nt),
                       .pair(pair), .spair(spair));

  assign is_sync  = (pos < SYNC_END);
  assign scr_adv  = tick && !is_sync;
  assign code_nxt = is_sync ? sync_code(pos[3:0], frame == '0)
                            : map_pair(spair[1], spair[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_stb     <= 1'b0;
      sf_start    <= 1'b0;
      sym_code    <= '0;
      out_is_sync <= 1'b0;
    end else begin
      sym_stb  <= tick;
      sf_start <= tick && (pos == '0) && (frame == '0);
      if (tick) begin
        sym_code    <= code_nxt;
        out_is_sync <= is_sync;
      end
    end
  end

  // superframe spacing monitor for the checks below
  logic [CNT_W-1:0] sf_gap;
  logic             sf_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_gap  <= '0;
      sf_seen <= 1'b0;
    end else if (sym_stb) begin
      sf_gap <= sf_start ? CNT_W'(1) : sf_gap + 1'b1;
      if (sf_start) sf_seen <= 1'b1;
    end
  end

  // R1
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> !sym_stb);
  // R3
  sf_first_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |-> (sym_stb && sym_code == Q_M3));
  // R3
  sf_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_start && sf_seen) |-> (sf_gap == CNT_W'(SF_SYMS)));
  // R2
  sync_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && out_is_sync) |-> (sym_code == Q_P3 || sym_code == Q_M3));
endmodule

// File: tb/test_qline_tx_framer.sv
module test_qline_tx_framer;
  localparam int CLK_PERIOD = 10;
  localparam int SYM_DIV    = 3;
  localparam int WDOG       = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_nt = 1'b1;
  logic       sync_ok = 1'b0;
  logic [7:0] b1_in = '0;
  logic [7:0] b2_in = '0;
  logic [1:0] d_in = '0;
  logic [5:0] oh_in = 6'b110010;
  logic       grp_take, sym_stb, sf_start;
  logic [1:0] sym_code;

  qline_tx_framer #(.SYM_DIV(SYM_DIV)) i_qline_tx_framer (
    .clk(clk), .rst_n(rst_n), .mode_nt(mode_nt), .sync_ok(sync_ok),
    .b1_in(b1_in), .b2_in(b2_in), .d_in(d_in), .oh_in(oh_in),
    .grp_take(grp_take), .sym_stb(sym_stb), .sym_code(sym_code), .sf_start(sf_start));

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_vec = 0, n_bad = 0, cyc = 0, last_stb = -1, k = 0, gcount = 0, sf_seen = 0;
  bit  done = 0, take_seen = 0, sync_req = 0;
  bit  bq[$];       // expected pre-scramble bits
  bit  gq[$];       // per bit: came from a gated group
  bit  hist[1:23];  // hist[j] = scrambled bit j steps back
  int  synclv[9] = '{3, 3, -3, -3, -3, 3, -3, 3, 3};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (symbol %0d)", tag, act, exp, k);
    end
  endtask

  function automatic logic [1:0] lvl_code(input int lv);
    case (lv)
      3:  return 2'b01;
      1:  return 2'b00;
      -1: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic bit scr_one(input bit din);
    bit o;
    o = din ^ hist[mode_nt ? 5 : 18] ^ hist[23];
    for (int j = 23; j > 1; j--) hist[j] = hist[j-1];
    hist[1] = o;
    return o;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // driver and monitor share one sampling point away from the rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bq.delete(); gq.delete();
      k = 0; last_stb = -1; take_seen = 0;
      for (int j = 1; j <= 23; j++) hist[j] = 0;
    end else begin
      if (take_seen) begin
        gcount++;
        if (gcount % 7 == 3) begin b1_in = 8'h00; b2_in = 8'hFF; end
        else begin b1_in = 8'(gcount * 29) ^ 8'h5A; b2_in = ~8'(gcount * 11); end
        d_in    = 2'(gcount);
        sync_ok = sync_req;
      end
      take_seen = grp_take;
      if (grp_take) begin
        int p;
        logic [17:0] w;
        p = k % 120;
        // R4: group load only at symbol positions 9+9g
        check(p >= 9 && p < 117 && (p - 9) % 9 == 0, "R4 grp_take position", p, 9);
        w = sync_ok ? {b1_in, b2_in, d_in} : 18'h3FFFF;
        for (int j = 17; j >= 0; j--) begin bq.push_back(w[j]); gq.push_back(!sync_ok); end
      end
      if (sym_stb) begin
        int p, fr;
        logic [1:0] exp_c;
        bit b0, b1b, s0, s1, gf;
        string tag;
        p  = k % 120;
        fr = (k / 120) % 12;
        check(sf_start == (p == 0 && fr == 0), "R3 sf_start flag", sf_start, p == 0 && fr == 0);
        if (sf_start) sf_seen++;
        if (last_stb >= 0) check(cyc - last_stb == SYM_DIV, "R1 strobe period", cyc - last_stb, SYM_DIV);
        last_stb = cyc;
        if (p < 9) begin
          exp_c = lvl_code(fr == 0 ? -synclv[p] : synclv[p]);
          tag = (fr == 0) ? "R3 inverted sync" : "R2 sync word";
        end else begin
          gf = 0;
          if (p >= 117) begin
            b0 = oh_in[5 - 2*(p-117)]; b1b = oh_in[4 - 2*(p-117)];
            tag = "R5 overhead";
          end else if (bq.size() >= 2) begin
            b0 = bq.pop_front(); b1b = bq.pop_front();
            gf = gq.pop_front(); gf = gq.pop_front() | gf;
            tag = gf ? "R8 gated ones" : (mode_nt ? "R6 payload NT" : "R7 payload LT");
          end else begin
            b0 = 0; b1b = 0;
            tag = "R4 missing group data";
            check(0, tag, 0, 2);
          end
          s0 = scr_one(b0);
          s1 = scr_one(b1b);
          // R9 level mapping
          exp_c = lvl_code(s0 ? (s1 ? 1 : 3) : (s1 ? -1 : -3));
          tag = {tag, " R9"};
        end
        check(sym_code == exp_c, tag, sym_code, exp_c);
        k++;
      end
    end
  end

  task automatic do_reset(input bit nt, input bit so);
    rst_n = 1'b0;
    mode_nt = nt;
    sync_req = so;
    sync_ok = so;
    repeat (4) @(negedge clk);
    // R10 outputs idle during reset
    check(sym_stb == 1'b0, "R10 reset strobe", sym_stb, 0);
    check(sf_start == 1'b0, "R10 reset sf_start", sf_start, 0);
    check(sym_code == 2'b00, "R10 reset code", sym_code, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    // phase 1: network-terminator end, gate closed then opened
    oh_in = 6'b110010;
    do_reset(1'b1, 1'b0);
    wait (k >= 300);
    sync_req = 1'b1;
    wait (k >= 1600);
    check(sf_seen == 2, "R3 superframe count", sf_seen, 2);

    // phase 2: line-terminator end, gate dropped briefly
    @(negedge clk);
    oh_in = 6'b011101;
    sf_seen = 0;
    do_reset(1'b0, 1'b1);
    wait (k >= 400);
    sync_req = 1'b0;
    wait (k >= 500);
    sync_req = 1'b1;
    wait (k >= 1500);
    check(sf_seen == 2, "R3 superframe count", sf_seen, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule